// File: doc/BRIEF.md
# Narrow-to-wide registered bus exchanger

This block links one narrow 12-bit port (A) to a wide side made of two 12-bit ports (1B and 2B) that together carry a 24-bit word. Going from narrow to wide, two A words written on successive clock edges come out together, the earlier one on 1B and the later one on 2B. The 1B path holds each word in two pipeline stages and the 2B path holds it in one register, which is what lines the pair up. Going from wide to narrow, the block stores the 1B and 2B words and drives one of them onto A, chosen by a select input that is sampled on the clock.

Every storage register has its own active-low load enable. The two active-low output enables are sampled on the clock, so a bus direction change takes effect on an edge. Each bidirectional port appears as separate input, output and drive-enable signals, so pad tristate buffers can be placed outside the block.

Top module: `wide_bus_exchanger`

## Requirements
- R1: A clock edge with `rst` high clears every data register and the sampled select to 0 and turns all three drive enables (`a_oe`, `b1_oe`, `b2_oe`) off (0).
- R2: At each edge where `en_a1_n` is 0, the 1B path takes in `a_in`, and `b1_out` then shows the word taken in at the previous such edge. So a word reaches `b1_out` after two enabled edges. When `en_a1_n` is 1, `b1_out` keeps its value.
- R3: At an edge where `en_a2_n` is 0, `b2_out` takes the value of `a_in` sampled at that edge. When `en_a2_n` is 1, `b2_out` keeps its value.
- R4: Suppose word W0 is applied with `en_a1_n`=0 and `en_a2_n`=1, and W1 is applied on the next edge with both enables 0. After that second edge, `b1_out` equals W0 and `b2_out` equals W1, in the same cycle.
- R5: At an edge where `en_1b_n` is 0, the 1B-to-A register stores `b1_in`. Otherwise it keeps its value.
- R6: At an edge where `en_2b_n` is 0, the 2B-to-A register stores `b2_in`. Otherwise it keeps its value.
- R7: `sel` is sampled on each edge. After an edge where `sel` was 1, `a_out` shows the 1B-to-A register, and after an edge where it was 0, `a_out` shows the 2B-to-A register. A change of `sel` between edges does not affect `a_out` until the next edge.
- R8: `oe_a_n` and `oe_b_n` are sampled on each edge. After the edge, `a_oe` is the inverse of the sampled `oe_a_n`, and `b1_oe` and `b2_oe` are both the inverse of the sampled `oe_b_n`. With both inputs high nothing drives. A alone drives only A, B alone drives only 1B and 2B, and both low drive all three ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Narrow port value seen from the pad |
| a_out | output | 12 | Narrow port value to drive |
| a_oe | output | 1 | Narrow port drive enable, active high |
| b1_in | input | 12 | Wide-side low port value seen from the pad |
| b1_out | output | 12 | Wide-side low port value to drive |
| b1_oe | output | 1 | Wide-side low port drive enable, active high |
| b2_in | input | 12 | Wide-side high port value seen from the pad |
| b2_out | output | 12 | Wide-side high port value to drive |
| b2_oe | output | 1 | Wide-side high port drive enable, active high |
| en_a1_n | input | 1 | Load enable, narrow-to-1B pipeline, active low |
| en_a2_n | input | 1 | Load enable, narrow-to-2B register, active low |
| en_1b_n | input | 1 | Load enable, 1B-to-narrow register, active low |
| en_2b_n | input | 1 | Load enable, 2B-to-narrow register, active low |
| sel | input | 1 | Wide-side source for port A: 1 picks 1B, 0 picks 2B |
| oe_a_n | input | 1 | Port A output enable, active low, sampled |
| oe_b_n | input | 1 | Port 1B/2B output enable, active low, sampled |

## Verification
The 2B output, the A output, the select and the drive enables all change one edge after the stimulus is sampled. The 1B output needs a second edge on which `en_a1_n` is low. The bench drives inputs on the falling edge. It compares every output against its behavioural model once just before the rising edge, which shows that nothing has moved early, and again at the next falling edge, by which time each result is due. A separate pairing check confirms that both halves of the wide word appear in the same cycle.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  parameter int XCHG_WORD_W = 12;

  // active-low load enables of the four storage paths
  typedef struct packed {
    logic a_to_1b;
    logic a_to_2b;
    logic b1_to_a;
    logic b2_to_a;
  } xchg_en_t;

endpackage

// File: rtl/xchg_pipe.sv
module xchg_pipe #(
  parameter int W     = 12,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= '0;
    end else if (!en_n) begin
      st[0] <= d;
      for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[DEPTH-1];

endmodule

// File: rtl/xchg_b2a.sv
module xchg_b2a #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en1_n,
  input  logic         en2_n,
  input  logic         sel,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] a_out
);

  logic [W-1:0] from1;
  logic [W-1:0] from2;
  logic         sel_q;

  xchg_pipe #(.W(W), .DEPTH(1)) i_r1 (
    .clk(clk), .rst(rst), .en_n(en1_n), .d(b1_in), .q(from1)
  );

  xchg_pipe #(.W(W), .DEPTH(1)) i_r2 (
    .clk(clk), .rst(rst), .en_n(en2_n), .d(b2_in), .q(from2)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= sel;
  end

  assign a_out = sel_q ? from1 : from2;

endmodule

// File: rtl/xchg_oe.sv
module xchg_oe (
  input  logic clk,
  input  logic rst,
  input  logic oe_a_n,
  input  logic oe_b_n,
  output logic a_oe,
  output logic b_oe
);

  logic oea_q;
  logic oeb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oea_q <= 1'b1;
      oeb_q <= 1'b1;
    end else begin
      oea_q <= oe_a_n;
      oeb_q <= oe_b_n;
    end
  end

  assign a_oe = ~oea_q;
  assign b_oe = ~oeb_q;

endmodule

// File: rtl/wide_bus_exchanger.sv
module wide_bus_exchanger #(
  parameter int W = xchg_pkg::XCHG_WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  input  logic         en_a1_n,
  input  logic         en_a2_n,
  input  logic         en_1b_n,
  input  logic         en_2b_n,
  input  logic         sel,
  input  logic         oe_a_n,
  input  logic         oe_b_n
);

  // the later word goes straight to 2B; the earlier one waits one more stage
  localparam int HI_DEPTH = 1;
  localparam int LO_DEPTH = HI_DEPTH + 1;

  xchg_pkg::xchg_en_t en;
  logic               b_oe;

  assign en = '{a_to_1b: en_a1_n, a_to_2b: en_a2_n,
                b1_to_a: en_1b_n, b2_to_a: en_2b_n};

  xchg_pipe #(.W(W), .DEPTH(LO_DEPTH)) i_lo (
    .clk(clk), .rst(rst), .en_n(en.a_to_1b), .d(a_in), .q(b1_out)
  );

  xchg_pipe #(.W(W), .DEPTH(HI_DEPTH)) i_hi (
    .clk(clk), .rst(rst), .en_n(en.a_to_2b), .d(a_in), .q(b2_out)
  );

  xchg_b2a #(.W(W)) i_b2a (
    .clk(clk), .rst(rst), .en1_n(en.b1_to_a), .en2_n(en.b2_to_a),
    .sel(sel), .b1_in(b1_in), .b2_in(b2_in), .a_out(a_out)
  );

  xchg_oe i_oe (
    .clk(clk), .rst(rst), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .a_oe(a_oe), .b_oe(b_oe)
  );

  assign b1_oe = b_oe;
  assign b2_oe = b_oe;

endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b1_out,
  input logic         b1_oe,
  input logic [W-1:0] b2_in,
  input logic [W-1:0] b2_out,
  input logic         b2_oe,
  input logic         en_a1_n,
  input logic         en_a2_n,
  input logic         en_1b_n,
  input logic         en_2b_n,
  input logic         sel,
  input logic         oe_a_n,
  input logic         oe_b_n
);

  // set after the first non-reset edge
  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b1_out == '0 && b2_out == '0 && !a_oe && !b1_oe && !b2_oe));

  assert_1b_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && !en_a1_n && $past(!en_a1_n)) |=> b1_out == $past(a_in, 2));

  assert_1b_hold_R2: assert property (@(posedge clk) disable iff (rst)
    en_a1_n |=> $stable(b1_out));

  assert_2b_load_R3: assert property (@(posedge clk) disable iff (rst)
    !en_a2_n |=> b2_out == $past(a_in));

  assert_2b_hold_R3: assert property (@(posedge clk) disable iff (rst)
    en_a2_n |=> $stable(b2_out));

  assert_a_from_1b_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_1b_n && sel) |=> a_out == $past(b1_in));

  assert_a_from_2b_R6: assert property (@(posedge clk) disable iff (rst)
    (!en_2b_n && !sel) |=> a_out == $past(b2_in));

  assert_a_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (run_q && en_1b_n && en_2b_n && sel == $past(sel)) |=> $stable(a_out));

  assert_oe_a_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_oe == !$past(oe_a_n));

  assert_oe_b_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (b1_oe == !$past(oe_b_n) && b2_oe == b1_oe));

endmodule

bind wide_bus_exchanger xchg_checker #(.W(W)) i_chk (.*);

// File: tb/test_wide_bus_exchanger.sv
module test_wide_bus_exchanger;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_oe, b1_oe, b2_oe;
  logic         en_a1_n, en_a2_n, en_1b_n, en_2b_n, sel, oe_a_n, oe_b_n;

  int checks = 0;
  int fails  = 0;

  // behavioural reference
  logic [W-1:0] m_lo_q[$];
  logic [W-1:0] m_hi, m_r1, m_r2;
  bit           m_sel, m_oea, m_oeb;

  always #2 clk = ~clk;

  wide_bus_exchanger #(.W(W)) i_wide_bus_exchanger (.*);

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string when_s);
    chk({"R2 b1_out ", when_s}, b1_out, m_lo_q[0]);
    chk({"R3 b2_out ", when_s}, b2_out, m_hi);
    chk({"R5 R6 R7 a_out ", when_s}, a_out, m_sel ? m_r1 : m_r2);
    chk({"R8 a_oe ", when_s}, W'(a_oe), W'(m_oea));
    chk({"R8 b1_oe ", when_s}, W'(b1_oe), W'(m_oeb));
    chk({"R8 b2_oe ", when_s}, W'(b2_oe), W'(m_oeb));
  endtask

  task automatic model_reset();
    m_lo_q = '{W'(0), W'(0)};
    m_hi = '0; m_r1 = '0; m_r2 = '0;
    m_sel = 0; m_oea = 0; m_oeb = 0;
  endtask

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b1, input logic [W-1:0] b2,
                      input logic ea1, input logic ea2, input logic e1b, input logic e2b,
                      input logic s, input logic oa, input logic ob);
    a_in = a; b1_in = b1; b2_in = b2;
    en_a1_n = ea1; en_a2_n = ea2; en_1b_n = e1b; en_2b_n = e2b;
    sel = s; oe_a_n = oa; oe_b_n = ob;
    #1 compare_all("before edge");
    @(posedge clk);
    if (!ea1) begin
      m_lo_q.push_back(a);
      void'(m_lo_q.pop_front());
    end
    if (!ea2) m_hi = a;
    if (!e1b) m_r1 = b1;
    if (!e2b) m_r2 = b2;
    m_sel = s;
    m_oea = !oa;
    m_oeb = !ob;
    @(negedge clk);
    compare_all("after edge");
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    a_in = 12'hfff; b1_in = 12'hfff; b2_in = 12'hfff;
    en_a1_n = 0; en_a2_n = 0; en_1b_n = 0; en_2b_n = 0;
    sel = 1; oe_a_n = 0; oe_b_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    // R1: reset state
    chk("R1 a_out", a_out, '0);
    chk("R1 b1_out", b1_out, '0);
    chk("R1 b2_out", b2_out, '0);
    chk("R1 oe", W'({a_oe, b1_oe, b2_oe}), '0);
    rst = 1'b0;

    // R3: single-edge 2B load, then hold
    step(12'h123, '0, '0, 1, 0, 1, 1, 0, 1, 1);
    step(12'h456, '0, '0, 1, 1, 1, 1, 0, 1, 1);

    // R2: one enabled edge is not enough, then a second one delivers; hold
    step(12'habc, '0, '0, 0, 1, 1, 1, 0, 1, 1);
    step(12'h777, '0, '0, 1, 1, 1, 1, 0, 1, 1);
    step(12'hdef, '0, '0, 0, 1, 1, 1, 0, 1, 1);
    chk("R2 two enabled edges", b1_out, 12'habc);

    // R4: pairing of two successive words
    step(12'h5a5, '0, '0, 0, 1, 1, 1, 0, 1, 1);
    step(12'h3c3, '0, '0, 0, 0, 1, 1, 0, 1, 1);
    chk("R4 earlier word on b1", b1_out, 12'h5a5);
    chk("R4 later word on b2", b2_out, 12'h3c3);

    // R5 R6 R7: wide to narrow capture and select
    step('0, 12'h111, 12'h222, 1, 1, 0, 0, 1, 0, 1);
    chk("R5 a_out from 1B", a_out, 12'h111);
    step('0, 12'h999, 12'h888, 1, 1, 1, 1, 0, 0, 1);
    chk("R6 a_out from 2B, regs held", a_out, 12'h222);
    step('0, 12'h999, 12'h888, 1, 1, 1, 1, 1, 0, 1);
    chk("R7 select back to 1B", a_out, 12'h111);
    step('0, 12'h999, 12'h333, 1, 1, 1, 0, 1, 0, 1);
    chk("R6 2B load while 1B shown", a_out, 12'h111);

    // R8: all four enable combinations
    step('0, '0, '0, 1, 1, 1, 1, 0, 1, 1);
    chk("R8 none drives", W'({a_oe, b1_oe, b2_oe}), W'(3'b000));
    step('0, '0, '0, 1, 1, 1, 1, 0, 0, 1);
    chk("R8 A only", W'({a_oe, b1_oe, b2_oe}), W'(3'b100));
    step('0, '0, '0, 1, 1, 1, 1, 0, 1, 0);
    chk("R8 B only", W'({a_oe, b1_oe, b2_oe}), W'(3'b011));
    step('0, '0, '0, 1, 1, 1, 1, 0, 0, 0);
    chk("R8 all drive", W'({a_oe, b1_oe, b2_oe}), W'(3'b111));

    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [6:0] c;
      c = 7'($urandom);
      step(W'($urandom), W'($urandom), W'($urandom),
           c[0], c[1], c[2], c[3], c[4], c[5], c[6]);
    end

    // R1: reset in the middle of traffic
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    model_reset();
    rst = 1'b0;
    chk("R1 mid-run b1_out", b1_out, '0);
    chk("R1 mid-run a_out", a_out, '0);
    chk("R1 mid-run oe", W'({a_oe, b1_oe, b2_oe}), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule